// File: doc/BRIEF.md
# Processor Status Word Register

This block is the 8-bit status word of a small CPU core. It keeps the arithmetic flags (zero, auxiliary carry, carry), the maskable-interrupt enable, a two-bit in-service priority level and the two bits that pick one of four working register banks. The execution pipeline drives it with ALU flag values and per-flag write enables. The decoder supplies strobes for enable-interrupts, disable-interrupts and bank select. The interrupt controller supplies an acknowledge strobe and the level of the request it accepted.

To save the word, the stack logic reads `psw_o` directly. A restore (interrupt return, break return or pop of the status word) presents the saved byte on the parallel load port. A load replaces the whole word and overrides any other update in the same cycle. The current bank number is also decoded to a two-bit output. The two bank bits sit apart in the word, so the decoder output saves the register-file logic from picking them out itself.

Top module: `psw_unit`

## Requirements
- R1: Asserting rst_ni low forces psw_o to 06h at once, without waiting for a clock edge. In that value both priority bits are 1 and every other bit is 0, so bank_o reads 0.
- R2: psw_o bit layout from bit 7 down to bit 0 is: interrupt enable, zero, bank bit 1, auxiliary carry, bank bit 0, priority bit 1, priority bit 0, carry. bank_o equals {psw_o[5], psw_o[3]}.
- R3: Zero, auxiliary carry and carry each take their input value at the next rising edge when their own write enable is high, and hold otherwise. For the zero flag, an input of 1 means the result was zero.
- R4: ei_i sets the interrupt enable and di_i clears it. When both are high in the same cycle, the enable ends up cleared.
- R5: int_ack_i clears the interrupt enable and loads the priority bits with int_lvl_i (bit 2 gets int_lvl_i[1]) at the same edge. It clears the enable even when ei_i is also high.
- R6: bank_we_i loads bank bit 1 from bank_i[1] and bank bit 0 from bank_i[0] at the next rising edge.
- R7: load_we_i writes load_data_i into the whole word at the next edge and overrides every other update requested in that cycle.
- R8: The priority bits change only on int_ack_i or load_we_i. Every other strobe leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_zero_i | input | 1 | ALU result-is-zero value for the zero flag |
| zero_we_i | input | 1 | Write enable for the zero flag |
| aux_cy_i | input | 1 | Auxiliary carry value |
| aux_cy_we_i | input | 1 | Write enable for auxiliary carry |
| cy_i | input | 1 | Carry value |
| cy_we_i | input | 1 | Write enable for carry |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| int_ack_i | input | 1 | Interrupt accepted strobe |
| int_lvl_i | input | 2 | Priority level of the accepted request |
| bank_we_i | input | 1 | Bank-select strobe |
| bank_i | input | 2 | Bank number to select |
| load_we_i | input | 1 | Restore strobe for the whole word |
| load_data_i | input | 8 | Word to restore |
| psw_o | output | 8 | Current status word, also the push source |
| bank_o | output | 2 | Selected bank number |

## Verification
Several properties are checked on every cycle:
- a restore lands exactly as presented;
- an acknowledge clears the enable and captures the level;
- enable set, disable and bank writes take effect at the next edge;
- flags and priority bits hold when they are not addressed.

Other behaviours appear only in the bench's scenarios. These are the fixed bit positions inside the byte, the 06h reset value and its asynchronous application mid-run, the disable-wins outcome of colliding strobes, and long sequences in which several fields change together.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W  = 8;
  localparam int LVL_W  = 2;
  localparam int BANK_W = 2;
  localparam int NFLAG  = 3;  // zero, aux carry, carry

  // bit positions shared by push/restore layout
  localparam int IE_B   = 7;
  localparam int Z_B    = 6;
  localparam int RBS1_B = 5;
  localparam int AC_B   = 4;
  localparam int RBS0_B = 3;
  localparam int ISP1_B = 2;
  localparam int ISP0_B = 1;
  localparam int CY_B   = 0;

  localparam logic [PSW_W-1:0] PSW_RST = 8'h06;
endpackage

// File: rtl/psw_alu_flags.sv
module psw_alu_flags #(
  parameter int            NF      = 3,
  parameter logic [NF-1:0] RST_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] val_i,
  input  logic [NF-1:0] we_i,
  input  logic          load_we_i,
  input  logic [NF-1:0] load_val_i,
  output logic [NF-1:0] q_o
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[g] <= RST_VAL[g];
      else if (load_we_i) q_o[g] <= load_val_i[g];
      else if (we_i[g])   q_o[g] <= val_i[g];
    end

    p_flag_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i[g] && !load_we_i) |=> (q_o[g] == $past(val_i[g])));
    p_flag_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!we_i[g] && !load_we_i) |=> $stable(q_o[g]));
  end
endmodule

// File: rtl/psw_irq_ctrl.sv
module psw_irq_ctrl #(
  parameter int               LVL_W   = 2,
  parameter logic             RST_IE  = 1'b0,
  parameter logic [LVL_W-1:0] RST_ISP = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ei_i,
  input  logic             di_i,
  input  logic             ack_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             load_we_i,
  input  logic             load_ie_i,
  input  logic [LVL_W-1:0] load_isp_i,
  output logic             ie_o,
  output logic [LVL_W-1:0] isp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_o  <= RST_IE;
      isp_o <= RST_ISP;
    end else if (load_we_i) begin
      ie_o  <= load_ie_i;
      isp_o <= load_isp_i;
    end else if (ack_i) begin
      ie_o  <= 1'b0;
      isp_o <= lvl_i;
    end else if (di_i) begin
      ie_o  <= 1'b0;  // disable wins over a simultaneous enable
    end else if (ei_i) begin
      ie_o  <= 1'b1;
    end
  end

  p_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !load_we_i) |=> (!ie_o && isp_o == $past(lvl_i)));
  p_ei_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ei_i && !di_i && !ack_i && !load_we_i) |=> ie_o);
  p_di_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (di_i && !load_we_i) |=> !ie_o);
  p_isp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_i && !load_we_i) |=> $stable(isp_o));
endmodule

// File: rtl/psw_bank_reg.sv
module psw_bank_reg #(
  parameter int                BANK_W   = 2,
  parameter logic [BANK_W-1:0] RST_BANK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              load_we_i,
  input  logic [BANK_W-1:0] load_bank_i,
  output logic [BANK_W-1:0] bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bank_o <= RST_BANK;
    else if (load_we_i) bank_o <= load_bank_i;
    else if (we_i)      bank_o <= bank_i;
  end

  p_bank_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !load_we_i) |=> (bank_o == $past(bank_i)));
  p_bank_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !load_we_i) |=> $stable(bank_o));
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_zero_i,
  input  logic              zero_we_i,
  input  logic              aux_cy_i,
  input  logic              aux_cy_we_i,
  input  logic              cy_i,
  input  logic              cy_we_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              int_ack_i,
  input  logic [LVL_W-1:0]  int_lvl_i,
  input  logic              bank_we_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              load_we_i,
  input  logic [PSW_W-1:0]  load_data_i,
  output logic [PSW_W-1:0]  psw_o,
  output logic [BANK_W-1:0] bank_o
);
  // flag vector order: {zero, aux carry, carry}
  localparam logic [NFLAG-1:0] FLAG_RST = {PSW_RST[Z_B], PSW_RST[AC_B], PSW_RST[CY_B]};
  localparam logic [LVL_W-1:0] ISP_RST  = {PSW_RST[ISP1_B], PSW_RST[ISP0_B]};
  localparam logic [BANK_W-1:0] BANK_RST = {PSW_RST[RBS1_B], PSW_RST[RBS0_B]};

  logic [NFLAG-1:0]  flags_q;
  logic [LVL_W-1:0]  isp_q;
  logic              ie_q;
  logic [BANK_W-1:0] bank_q;

  psw_alu_flags #(.NF(NFLAG), .RST_VAL(FLAG_RST)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .val_i      ({res_zero_i, aux_cy_i, cy_i}),
    .we_i       ({zero_we_i, aux_cy_we_i, cy_we_i}),
    .load_we_i  (load_we_i),
    .load_val_i ({load_data_i[Z_B], load_data_i[AC_B], load_data_i[CY_B]}),
    .q_o        (flags_q)
  );

  psw_irq_ctrl #(.LVL_W(LVL_W), .RST_IE(PSW_RST[IE_B]), .RST_ISP(ISP_RST)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ei_i       (ei_i),
    .di_i       (di_i),
    .ack_i      (int_ack_i),
    .lvl_i      (int_lvl_i),
    .load_we_i  (load_we_i),
    .load_ie_i  (load_data_i[IE_B]),
    .load_isp_i ({load_data_i[ISP1_B], load_data_i[ISP0_B]}),
    .ie_o       (ie_q),
    .isp_o      (isp_q)
  );

  psw_bank_reg #(.BANK_W(BANK_W), .RST_BANK(BANK_RST)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (bank_we_i),
    .bank_i      (bank_i),
    .load_we_i   (load_we_i),
    .load_bank_i ({load_data_i[RBS1_B], load_data_i[RBS0_B]}),
    .bank_o      (bank_q)
  );

  always_comb begin
    psw_o         = '0;
    psw_o[IE_B]   = ie_q;
    psw_o[Z_B]    = flags_q[2];
    psw_o[RBS1_B] = bank_q[1];
    psw_o[AC_B]   = flags_q[1];
    psw_o[RBS0_B] = bank_q[0];
    psw_o[ISP1_B] = isp_q[1];
    psw_o[ISP0_B] = isp_q[0];
    psw_o[CY_B]   = flags_q[0];
  end

  assign bank_o = bank_q;

  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_i |=> (psw_o == $past(load_data_i)));
endmodule

// File: tb/psw_unit_test.sv
module psw_unit_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       res_zero_i = 1'b0, zero_we_i = 1'b0;
  logic       aux_cy_i = 1'b0, aux_cy_we_i = 1'b0;
  logic       cy_i = 1'b0, cy_we_i = 1'b0;
  logic       ei_i = 1'b0, di_i = 1'b0, int_ack_i = 1'b0;
  logic [1:0] int_lvl_i = '0;
  logic       bank_we_i = 1'b0;
  logic [1:0] bank_i = '0;
  logic       load_we_i = 1'b0;
  logic [7:0] load_data_i = '0;
  logic [7:0] psw_o;
  logic [1:0] bank_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  psw_unit uut (.*);

  typedef struct packed {
    logic [15:0] tag;
    logic        ld;
    logic [7:0]  ld_d;
    logic        ei, di, ack;
    logic [1:0]  lvl;
    logic        bwe;
    logic [1:0]  bnk;
    logic        zwe, z, awe, ac, cwe, cy;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 15;
  // each row is applied for one cycle from reset value 06h onward
  localparam vec_t VEC [NV] = '{
    '{"R4", 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h86},
    '{"R3", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC6},
    '{"R3", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hD7},
    '{"R6", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF},
    '{"R6", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hDF},
    '{"R3", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h9F},
    '{"R4", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h1F},
    '{"R4", 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h1F},
    '{"R4", 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h9F},
    '{"R5", 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h1B},
    '{"R7", 1'b1, 8'h5A, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A},
    '{"R7", 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
    '{"R3", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hB5},
    '{"R8", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hB5},
    '{"R5", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h31}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic idle();
    ei_i = 0; di_i = 0; int_ack_i = 0; int_lvl_i = 0;
    bank_we_i = 0; bank_i = 0; load_we_i = 0; load_data_i = 0;
    zero_we_i = 0; res_zero_i = 0; aux_cy_we_i = 0; aux_cy_i = 0;
    cy_we_i = 0; cy_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset value held through clock edges
    chk("R1", psw_o, 8'h06);
    chk("R1", {6'd0, bank_o}, 8'h00);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      load_we_i = VEC[i].ld;  load_data_i = VEC[i].ld_d;
      ei_i = VEC[i].ei;  di_i = VEC[i].di;  int_ack_i = VEC[i].ack;
      int_lvl_i = VEC[i].lvl;
      bank_we_i = VEC[i].bwe;  bank_i = VEC[i].bnk;
      zero_we_i = VEC[i].zwe;  res_zero_i = VEC[i].z;
      aux_cy_we_i = VEC[i].awe;  aux_cy_i = VEC[i].ac;
      cy_we_i = VEC[i].cwe;  cy_i = VEC[i].cy;
      @(negedge clk_i);
      chk(string'(VEC[i].tag), psw_o, VEC[i].exp);
      // R2: bank_o mirrors bits 5 and 3
      chk("R2", {6'd0, bank_o}, {6'd0, VEC[i].exp[5], VEC[i].exp[3]});
      idle();
    end

    // R8: bank write and flag writes leave priority bits alone
    @(negedge clk_i);
    bank_we_i = 1; bank_i = 2'd2; cy_we_i = 1; cy_i = 1; ei_i = 1;
    @(negedge clk_i);
    chk("R8", {6'd0, psw_o[2:1]}, 8'h00);
    chk("R6", {6'd0, bank_o}, 8'h02);
    idle();

    // R1: asynchronous reset mid-run, between clock edges
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1", psw_o, 8'h06);
    chk("R1", {6'd0, bank_o}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", psw_o, 8'h06);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule